// File: doc/BRIEF.md
# Local Interrupt Priority Controller

A per-processor controller that tracks up to 256 interrupt vectors and decides which of them may interrupt the processor. It has three bit arrays: pending, in-service and trigger mode. Sources inject a vector number together with a level/edge flag. The controller compares the highest pending vector with the current processor priority and raises a request line when that vector's priority class is strictly higher. The processor runs acknowledge cycles, and each one is answered with the vector, with the programmed spurious vector, or with "none".

Software writes a task priority, a spurious vector register (spurious vector number, enable, directed-EOI disable) and end-of-interrupt commands through a single write port. An end-of-interrupt retires the highest in-service vector. When that vector was level-triggered and directed EOI is off, the block emits a one-cycle broadcast pulse carrying the vector, so that upstream routing logic can rearm the source.

Top module: `lic_core`

## Requirements
- R1: An active-low asynchronous reset clears the pending, in-service and trigger-mode arrays, the task priority and the enable and directed-EOI bits. After reset `irq_o`, `ack_rsp_o` and `eoi_bc_o` are low.
- R2: While the enable bit (bit 8 of the spurious vector register) is clear, `irq_o` stays low and every acknowledge returns kind none (0) with vector 0, leaving all state unchanged.
- R3: Processor priority equals the task priority when the task priority's class (upper 4 bits) is at least the class of the highest in-service vector, or when nothing is in service. Otherwise it equals that in-service class with the low nibble zero.
- R4: The highest pending vector is deliverable only when the processor priority is zero or its class is strictly greater than the processor priority's class. An equal class blocks it.
- R5: An acknowledge pulse on `ack_i` gives `ack_rsp_o` high in the following cycle, with `ack_kind_o` 0 (none), 1 (spurious) or 2 (vector). With nothing pending the kind is none. Without `ack_i` there is no response.
- R6: An acknowledge that finds the highest pending vector blocked returns kind spurious with the low 8 bits of the spurious vector register, and the pending array is unchanged.
- R7: An acknowledge that finds a deliverable vector returns that vector (the largest pending index), clears its pending bit and sets its in-service bit.
- R8: An EOI command clears the highest set in-service bit. With the in-service array empty it has no effect.
- R9: The EOI broadcast pulses for one cycle with the retired vector only when bit 12 of the spurious vector register (directed EOI) is clear and that vector's trigger-mode bit is set.
- R10: Injecting a vector sets its pending bit and writes its trigger-mode bit from `inj_level_i` (1 = level, 0 = edge). A later edge injection clears the bit again.
- R11: `irq_o` is registered. It reflects the state one clock after the state changes, so it moves two edges after the causing input is sampled.
- R12: The write select chooses task priority (0), spurious vector register (1) or EOI (2). Select 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 task priority, 1 spurious vector reg, 2 EOI, 3 none |
| wr_data_i | input | 16 | Write data |
| inj_valid_i | input | 1 | Inject strobe |
| inj_vec_i | input | 8 | Injected vector number |
| inj_level_i | input | 1 | Trigger mode of injected vector, 1 = level |
| ack_i | input | 1 | Acknowledge strobe |
| ack_rsp_o | output | 1 | Acknowledge response valid |
| ack_kind_o | output | 2 | 0 none, 1 spurious, 2 vector |
| ack_vec_o | output | 8 | Returned vector |
| irq_o | output | 1 | Interrupt request to the processor |
| eoi_bc_o | output | 1 | EOI broadcast pulse |
| eoi_bc_vec_o | output | 8 | Vector carried by the broadcast |

## Verification
On every cycle the checker holds the request line and acknowledge kind against the enable bit. It also checks that every returned vector lies above the processor-priority class, that a spurious answer carries the programmed spurious number, and that an acknowledged vector has moved from pending to in-service. The broadcast is checked against the directed-EOI bit and the trigger-mode bit, and every injection against the trigger-mode bit it must leave behind. Only the bench scenarios can show the rest: which vector an EOI retires when several are nested, the equal-class blocking boundary, and a pending vector surviving a spurious acknowledge so that it is delivered once the task priority drops. The same holds for select 3 having no effect, the cleared state after a mid-run reset, and the two-edge latency of the request line.

// File: rtl/lic_pkg.sv
package lic_pkg;
  localparam int unsigned VEC_W        = 8;
  localparam int unsigned NUM_VEC      = 1 << VEC_W;
  localparam int unsigned CLS_W        = 4;
  localparam int unsigned DATA_W       = 16;
  localparam int unsigned SVR_EN_BIT   = 8;
  localparam int unsigned SVR_DEOI_BIT = 12;

  typedef enum logic [1:0] {
    SEL_TPR  = 2'd0,
    SEL_SVR  = 2'd1,
    SEL_EOI  = 2'd2,
    SEL_NONE = 2'd3
  } wr_sel_e;

  typedef enum logic [1:0] {
    ACK_NONE = 2'd0,
    ACK_SPUR = 2'd1,
    ACK_VEC  = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/lic_prio_enc.sv
// Largest set index wins.
module lic_prio_enc #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/lic_vec_state.sv
module lic_vec_state #(
  parameter int unsigned NUM = 256
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NUM-1:0] irr_set_i,
  input  logic [NUM-1:0] irr_clr_i,
  input  logic [NUM-1:0] isr_set_i,
  input  logic [NUM-1:0] isr_clr_i,
  input  logic [NUM-1:0] tmr_we_i,
  input  logic           tmr_lvl_i,
  output logic [NUM-1:0] irr_o,
  output logic [NUM-1:0] isr_o,
  output logic [NUM-1:0] tmr_o
);
  for (genvar g = 0; g < NUM; g++) begin : g_bit
    logic irr_b, isr_b, tmr_b;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        irr_b <= 1'b0;
        isr_b <= 1'b0;
        tmr_b <= 1'b0;
      end else begin
        // acknowledge beats a same-cycle inject of the same vector
        if (irr_clr_i[g])      irr_b <= 1'b0;
        else if (irr_set_i[g]) irr_b <= 1'b1;
        if (isr_set_i[g])      isr_b <= 1'b1;
        else if (isr_clr_i[g]) isr_b <= 1'b0;
        if (tmr_we_i[g])       tmr_b <= tmr_lvl_i;
      end
    end
    assign irr_o[g] = irr_b;
    assign isr_o[g] = isr_b;
    assign tmr_o[g] = tmr_b;
  end
endmodule

// File: rtl/lic_prio_calc.sv
module lic_prio_calc #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CLS_W = 4
) (
  input  logic             irr_valid_i,
  input  logic [VEC_W-1:0] irr_top_i,
  input  logic             isr_valid_i,
  input  logic [VEC_W-1:0] isr_top_i,
  input  logic [VEC_W-1:0] tpr_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             deliver_o,
  output logic             blocked_o
);
  localparam int unsigned LOW_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;

  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_top_i[VEC_W-1 -: CLS_W];
  assign irr_cls = irr_top_i[VEC_W-1 -: CLS_W];

  assign ppr_o   = (!isr_valid_i || tpr_cls >= isr_cls) ? tpr_i
                                                        : {isr_cls, {LOW_W{1'b0}}};
  assign ppr_cls = ppr_o[VEC_W-1 -: CLS_W];

  assign deliver_o = irr_valid_i && ((ppr_o == '0) || (irr_cls > ppr_cls));
  assign blocked_o = irr_valid_i && !deliver_o;
endmodule

// File: rtl/lic_core.sv
module lic_core #(
  parameter int unsigned VEC_W        = lic_pkg::VEC_W,
  parameter int unsigned CLS_W        = lic_pkg::CLS_W,
  parameter int unsigned DATA_W       = lic_pkg::DATA_W,
  parameter int unsigned SVR_EN_BIT   = lic_pkg::SVR_EN_BIT,
  parameter int unsigned SVR_DEOI_BIT = lic_pkg::SVR_DEOI_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              inj_valid_i,
  input  logic [VEC_W-1:0]  inj_vec_i,
  input  logic              inj_level_i,
  input  logic              ack_i,
  output logic              ack_rsp_o,
  output logic [1:0]        ack_kind_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic              irq_o,
  output logic              eoi_bc_o,
  output logic [VEC_W-1:0]  eoi_bc_vec_o
);
  import lic_pkg::*;

  localparam int unsigned NUM_VEC = 1 << VEC_W;
  localparam logic [NUM_VEC-1:0] ONE = NUM_VEC'(1);

  logic [VEC_W-1:0] tpr_q, spur_q;
  logic             en_q, deoi_q;

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_set, irr_clr, isr_set, isr_clr;
  logic               irr_valid, isr_valid;
  logic [VEC_W-1:0]   irr_top, isr_top;
  logic [VEC_W-1:0]   ppr;
  logic               deliver, blocked;

  logic tpr_we, svr_we, eoi_we, ack_take, eoi_do;

  assign tpr_we = wr_en_i && (wr_sel_i == SEL_TPR);
  assign svr_we = wr_en_i && (wr_sel_i == SEL_SVR);
  assign eoi_we = wr_en_i && (wr_sel_i == SEL_EOI);

  assign ack_take = ack_i && en_q && deliver;
  assign eoi_do   = eoi_we && isr_valid;

  assign irr_set = inj_valid_i ? (ONE << inj_vec_i) : '0;
  assign irr_clr = ack_take    ? (ONE << irr_top)   : '0;
  assign isr_set = irr_clr;
  assign isr_clr = eoi_do      ? (ONE << isr_top)   : '0;

  lic_vec_state #(.NUM(NUM_VEC)) u_state (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irr_set_i (irr_set),
    .irr_clr_i (irr_clr),
    .isr_set_i (isr_set),
    .isr_clr_i (isr_clr),
    .tmr_we_i  (irr_set),
    .tmr_lvl_i (inj_level_i),
    .irr_o     (irr_q),
    .isr_o     (isr_q),
    .tmr_o     (tmr_q)
  );

  lic_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_irr_enc (
    .vec_i   (irr_q),
    .valid_o (irr_valid),
    .idx_o   (irr_top)
  );

  lic_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_isr_enc (
    .vec_i   (isr_q),
    .valid_o (isr_valid),
    .idx_o   (isr_top)
  );

  lic_prio_calc #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_calc (
    .irr_valid_i (irr_valid),
    .irr_top_i   (irr_top),
    .isr_valid_i (isr_valid),
    .isr_top_i   (isr_top),
    .tpr_i       (tpr_q),
    .ppr_o       (ppr),
    .deliver_o   (deliver),
    .blocked_o   (blocked)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q  <= '0;
      spur_q <= '1;
      en_q   <= 1'b0;
      deoi_q <= 1'b0;
    end else begin
      if (tpr_we) tpr_q <= wr_data_i[VEC_W-1:0];
      if (svr_we) begin
        spur_q <= wr_data_i[VEC_W-1:0];
        en_q   <= wr_data_i[SVR_EN_BIT];
        deoi_q <= wr_data_i[SVR_DEOI_BIT];
      end
    end
  end

  ack_kind_e kind_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    kind_d = ACK_NONE;
    vec_d  = '0;
    if (en_q) begin
      if (deliver) begin
        kind_d = ACK_VEC;
        vec_d  = irr_top;
      end else if (blocked) begin
        kind_d = ACK_SPUR;
        vec_d  = spur_q;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_rsp_o    <= 1'b0;
      ack_kind_o   <= ACK_NONE;
      ack_vec_o    <= '0;
      irq_o        <= 1'b0;
      eoi_bc_o     <= 1'b0;
      eoi_bc_vec_o <= '0;
    end else begin
      ack_rsp_o    <= ack_i;
      ack_kind_o   <= ack_i ? kind_d : ACK_NONE;
      ack_vec_o    <= ack_i ? vec_d : '0;
      irq_o        <= en_q && deliver;
      eoi_bc_o     <= eoi_do && !deoi_q && tmr_q[isr_top];
      eoi_bc_vec_o <= eoi_do ? isr_top : '0;
    end
  end
endmodule

// File: rtl/lic_core_chk.sv
module lic_core_chk #(
  parameter int unsigned VEC_W = 8,
  parameter int unsigned CLS_W = 4,
  parameter int unsigned NUM   = 256
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             deoi_i,
  input logic [VEC_W-1:0] spur_i,
  input logic [VEC_W-1:0] ppr_i,
  input logic [NUM-1:0]   irr_i,
  input logic [NUM-1:0]   isr_i,
  input logic [NUM-1:0]   tmr_i,
  input logic             inj_valid_i,
  input logic [VEC_W-1:0] inj_vec_i,
  input logic             inj_level_i,
  input logic             ack_i,
  input logic             ack_rsp_o,
  input logic [1:0]       ack_kind_o,
  input logic [VEC_W-1:0] ack_vec_o,
  input logic             irq_o,
  input logic             eoi_bc_o,
  input logic [VEC_W-1:0] eoi_bc_vec_o
);
  logic [NUM-1:0] tmr_prev;
  always_ff @(posedge clk_i) tmr_prev <= tmr_i;

  a_r2_off_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> !irq_o);

  a_r2_off_ack_none: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rsp_o && !$past(en_i)) |-> (ack_kind_o == 2'd0));

  a_r5_no_idle_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(ack_i) |-> !ack_rsp_o);

  a_r4_vec_above_ppr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rsp_o && ack_kind_o == 2'd2) |->
      (($past(ppr_i) == '0) ||
       (ack_vec_o[VEC_W-1 -: CLS_W] > $past(ppr_i[VEC_W-1 -: CLS_W]))));

  a_r6_spur_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rsp_o && ack_kind_o == 2'd1) |-> (ack_vec_o == $past(spur_i)));

  a_r7_moved_to_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rsp_o && ack_kind_o == 2'd2) |-> (isr_i[ack_vec_o] && !irr_i[ack_vec_o]));

  a_r8_eoi_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bc_o |-> !isr_i[eoi_bc_vec_o]);

  a_r9_bc_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_bc_o |-> (!$past(deoi_i) && tmr_prev[eoi_bc_vec_o]));

  a_r10_inj_tmr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(inj_valid_i) |-> (tmr_i[$past(inj_vec_i)] == $past(inj_level_i)));
endmodule

bind lic_core lic_core_chk #(.VEC_W(VEC_W), .CLS_W(CLS_W), .NUM(NUM_VEC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_q),
  .deoi_i       (deoi_q),
  .spur_i       (spur_q),
  .ppr_i        (ppr),
  .irr_i        (irr_q),
  .isr_i        (isr_q),
  .tmr_i        (tmr_q),
  .inj_valid_i  (inj_valid_i),
  .inj_vec_i    (inj_vec_i),
  .inj_level_i  (inj_level_i),
  .ack_i        (ack_i),
  .ack_rsp_o    (ack_rsp_o),
  .ack_kind_o   (ack_kind_o),
  .ack_vec_o    (ack_vec_o),
  .irq_o        (irq_o),
  .eoi_bc_o     (eoi_bc_o),
  .eoi_bc_vec_o (eoi_bc_vec_o)
);

// File: tb/lic_core_tb.sv
`timescale 1ns/1ps
module lic_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [15:0] wr_data = '0;
  logic        inj_valid = 1'b0;
  logic [7:0]  inj_vec = '0;
  logic        inj_level = 1'b0;
  logic        ack = 1'b0;
  logic        ack_rsp, irq, bc;
  logic [1:0]  ack_kind;
  logic [7:0]  ack_vec, bc_vec;

  int n_checks = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  lic_core u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .wr_en_i      (wr_en),
    .wr_sel_i     (wr_sel),
    .wr_data_i    (wr_data),
    .inj_valid_i  (inj_valid),
    .inj_vec_i    (inj_vec),
    .inj_level_i  (inj_level),
    .ack_i        (ack),
    .ack_rsp_o    (ack_rsp),
    .ack_kind_o   (ack_kind),
    .ack_vec_o    (ack_vec),
    .irq_o        (irq),
    .eoi_bc_o     (bc),
    .eoi_bc_vec_o (bc_vec)
  );

  localparam logic [2:0] OP_INJ = 3'd0, OP_TPR = 3'd1, OP_SVR = 3'd2,
                         OP_EOI = 3'd3, OP_ACK = 3'd4, OP_SEL3 = 3'd5;
  localparam logic [1:0] K_NONE = 2'd0, K_SPUR = 2'd1, K_VEC = 2'd2;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] data;
    logic        lvl;
    logic [1:0]  kind;
    logic [7:0]  vec;
    logic        bc;
    logic        irq;
    logic [3:0]  req;
  } step_t;

  localparam int N_STEPS = 46;
  localparam step_t TBL [N_STEPS] = '{
    '{OP_ACK,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 disabled, empty
    '{OP_INJ,  16'h0041, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 no irq while off
    '{OP_ACK,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd2},  // R2 none while off
    '{OP_SVR,  16'h013F, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd12}, // R12 enable
    '{OP_TPR,  16'h0050, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 class 4 <= 5
    '{OP_ACK,  16'h0000, 1'b0, K_SPUR, 8'h3F, 1'b0, 1'b0, 4'd6},  // R6 spurious
    '{OP_TPR,  16'h0040, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 equal class blocks
    '{OP_TPR,  16'h003F, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd4},  // R4 4 > 3
    '{OP_INJ,  16'h0092, 1'b1, K_NONE, 8'h00, 1'b0, 1'b1, 4'd10}, // R10 level
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h92, 1'b0, 1'b0, 4'd7},  // R7 highest taken
    '{OP_INJ,  16'h0095, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd3},  // R3 isr class 9 masks
    '{OP_INJ,  16'h00A0, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd3},  // R3 class A above
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'hA0, 1'b0, 1'b0, 4'd7},  // R7 nested
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd8},  // R8 retire A0 edge
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h92, 1'b1, 1'b1, 4'd9},  // R9 level bc 92
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h95, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_SVR,  16'h113F, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 directed on
    '{OP_INJ,  16'h00C7, 1'b1, K_NONE, 8'h00, 1'b0, 1'b1, 4'd10}, // R10
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'hC7, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 suppressed
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 retire 95
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd8},  // R8 empty isr
    '{OP_TPR,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd3},  // R3
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h41, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_ACK,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd5},  // R5 nothing pending
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd8},  // R8
    '{OP_SEL3, 16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd12}, // R12 sel 3 no write
    '{OP_INJ,  16'h0030, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd12}, // R12 still enabled
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h30, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd8},  // R8
    '{OP_SVR,  16'h0120, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd9},  // R9 directed off
    '{OP_INJ,  16'h0070, 1'b1, K_NONE, 8'h00, 1'b0, 1'b1, 4'd10}, // R10 level
    '{OP_INJ,  16'h0070, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd10}, // R10 re-edge
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h70, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd10}, // R10 tmr cleared
    '{OP_INJ,  16'h0071, 1'b1, K_NONE, 8'h00, 1'b0, 1'b1, 4'd10}, // R10
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h71, 1'b0, 1'b0, 4'd7},  // R7
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h71, 1'b1, 1'b0, 4'd9},  // R9 bc 71
    '{OP_TPR,  16'h0080, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd4},  // R4
    '{OP_INJ,  16'h0085, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 equal class
    '{OP_ACK,  16'h0000, 1'b0, K_SPUR, 8'h20, 1'b0, 1'b0, 4'd6},  // R6
    '{OP_TPR,  16'h0070, 1'b0, K_NONE, 8'h00, 1'b0, 1'b1, 4'd6},  // R6 irr kept
    '{OP_ACK,  16'h0000, 1'b0, K_VEC,  8'h85, 1'b0, 1'b0, 4'd6},  // R6 delivered later
    '{OP_EOI,  16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd8},  // R8
    '{OP_INJ,  16'h0050, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 5 <= 7
    '{OP_SVR,  16'h0020, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd2}   // R2 disable
  };

  task automatic check(input bit ok, input int req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_inputs();
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    inj_valid = 1'b0; inj_vec = '0; inj_level = 1'b0; ack = 1'b0;
  endtask

  task automatic run_step(input step_t s);
    case (s.op)
      OP_INJ:  begin inj_valid = 1'b1; inj_vec = s.data[7:0]; inj_level = s.lvl; end
      OP_TPR:  begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = s.data; end
      OP_SVR:  begin wr_en = 1'b1; wr_sel = 2'd1; wr_data = s.data; end
      OP_EOI:  begin wr_en = 1'b1; wr_sel = 2'd2; wr_data = s.data; end
      OP_SEL3: begin wr_en = 1'b1; wr_sel = 2'd3; wr_data = s.data; end
      default: ack = 1'b1;
    endcase
    @(negedge clk);
    clear_inputs();
    if (s.op == OP_ACK) begin
      check(ack_rsp == 1'b1, int'(s.req), "ack_rsp", ack_rsp, 1);
      check(ack_kind == s.kind, int'(s.req), "ack_kind", ack_kind, s.kind);
      check(ack_vec == s.vec, int'(s.req), "ack_vec", ack_vec, s.vec);
    end else begin
      check(ack_rsp == 1'b0, 5, "idle ack_rsp", ack_rsp, 0); // R5
    end
    check(bc == s.bc, int'(s.req), "eoi_bc", bc, s.bc);
    if (s.bc) check(bc_vec == s.vec, int'(s.req), "eoi_bc_vec", bc_vec, s.vec);
    @(negedge clk);
    check(irq == s.irq, int'(s.req), "irq", irq, s.irq);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    clear_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the outputs
    check(irq == 1'b0, 1, "reset irq", irq, 0);
    check(ack_rsp == 1'b0, 1, "reset ack_rsp", ack_rsp, 0);
    check(bc == 1'b0, 1, "reset eoi_bc", bc, 0);

    for (int i = 0; i < N_STEPS; i++) run_step(TBL[i]);

    // R1 mid-run reset: vector 50 pending before, must be gone after
    rst_n = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, 1, "async reset irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_step('{OP_SVR, 16'h0100, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd1}); // R1 irr cleared
    run_step('{OP_ACK, 16'h0000, 1'b0, K_NONE, 8'h00, 1'b0, 1'b0, 4'd1}); // R1 nothing pending

    // R11 request latency: two edges after inject
    inj_valid = 1'b1; inj_vec = 8'h60; inj_level = 1'b0;
    @(negedge clk);
    clear_inputs();
    check(irq == 1'b0, 11, "irq one edge after inject", irq, 0);
    @(negedge clk);
    check(irq == 1'b1, 11, "irq two edges after inject", irq, 1);

    // R11 request drop latency after acknowledge
    ack = 1'b1;
    @(negedge clk);
    clear_inputs();
    check(ack_kind == K_VEC && ack_vec == 8'h60, 11, "ack 60", ack_vec, 8'h60);
    check(irq == 1'b1, 11, "irq one edge after ack", irq, 1);
    @(negedge clk);
    check(irq == 1'b0, 11, "irq two edges after ack", irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule